// File: doc/BRIEF.md
# Spread-Spectrum Chip Generator with Synchronization Preamble

This block turns a serial stream of data bits into a single-bit chip stream for a direct-sequence spread-spectrum link. After a start strobe it first puts a fixed 8-chip synchronization word on the line. It then spreads every data bit over an 8-chip code by XOR-ing the bit with the current code chip. The code register rotates, so the same 8-chip pattern repeats for every bit.

The block does not time its own chips. An external clock master supplies load and chip-enable strobes for the sync-word register and the code register. Its usual chip enable comes every fourth main clock, so each data bit lasts 32 main clocks. The line leaves through a register with its own enable.

A three-state phase machine sequences the work. IDLE holds after reset and drives 0. PREAMBLE is entered on a sync load from any state (transition START). PAYLOAD is entered after the eighth sync chip enable (transition SYNC_DONE). PAYLOAD is held until the next sync load, which takes the machine back to PREAMBLE (transition RESTART).

Top module: `dsss_preamble_spreader`

## Requirements
- R1: While `rst_n` is low, and after reset until the first `sync_load`, the phase is IDLE and `line_chip` is 0. Chip enables have no effect on the line in IDLE.
- R2: A `sync_load` in any phase loads the sync word, clears the sync chip count and enters PREAMBLE (transitions START and RESTART).
- R3: In PREAMBLE the line carries the sync word MSB first. The default word is 8'b1110_0100, so the chips are 1,1,1,0,0,1,0,0. Each `sync_chip_en` moves to the next bit.
- R4: PREAMBLE lasts exactly 8 sync chip enables (transition SYNC_DONE). No spread data reaches the line before the last sync chip has been sent.
- R5: In PAYLOAD the chip is `data_bit` XOR the current code chip. The code is taken MSB first, default 8'b1011_0001. Each `code_chip_en` rotates the code left by one. The code register does not move outside PAYLOAD.
- R6: A `code_load` reloads the code, so the next chip uses code bit 7 again.
- R7: When `out_en` is 1, `line_chip` shows the chip computed in the previous clock. When `out_en` is 0, `line_chip` keeps its value.
- R8: A load strobe takes priority over the chip enable of the same register in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_bit | input | 1 | Serial data bit to spread |
| sync_load | input | 1 | Load sync word and start preamble |
| sync_chip_en | input | 1 | Advance sync word by one chip |
| code_load | input | 1 | Reload spreading code |
| code_chip_en | input | 1 | Rotate spreading code by one chip |
| out_en | input | 1 | Output register enable |
| line_chip | output | 1 | Registered chip stream |

## Verification
Every result appears on `line_chip` exactly one clock after the edge that produced it. A load or chip enable changes the internal registers at edge N. The line shows the new chip at edge N+1, and only if `out_en` was 1 at that edge. The bench model steps on each rising edge with the same one-register delay and compares at every falling edge. Each check is tagged with the requirement for the model's current phase. The bench covers preamble-to-payload, output holds, restarts during payload, code reloads, and loads that coincide with enables.

// File: rtl/dsss_spreader_pkg.sv
package dsss_spreader_pkg;
    typedef enum logic [1:0] {
        PH_IDLE     = 2'd0,
        PH_PREAMBLE = 2'd1,
        PH_PAYLOAD  = 2'd2
    } phase_e;
endpackage

// File: rtl/dsss_sync_shifter.sv
module dsss_sync_shifter #(
    parameter int              LEN  = 8,
    parameter logic [LEN-1:0]  WORD = 8'b1110_0100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic advance,
    output logic chip,
    output logic last
);
    localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;

    logic [LEN-1:0] word_q;
    logic [CW-1:0]  cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            word_q <= WORD;
            cnt_q  <= '0;
        end else if (advance) begin
            word_q <= {word_q[LEN-2:0], 1'b0};
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign chip = word_q[LEN-1];
    assign last = (cnt_q == CW'(LEN - 1));

    // R2 / R8: a load always presents the first word bit next clock
    p_load_first_chip_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (chip == WORD[LEN-1]));
endmodule

// File: rtl/dsss_code_rotator.sv
module dsss_code_rotator #(
    parameter int              LEN  = 8,
    parameter logic [LEN-1:0]  CODE = 8'b1011_0001
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic advance,
    output logic chip
);
    logic [LEN-1:0] code_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            code_q <= CODE;
        else if (load)
            code_q <= CODE;
        else if (advance)
            code_q <= {code_q[LEN-2:0], code_q[LEN-1]};
    end

    assign chip = code_q[LEN-1];

    // R6 / R8: reload wins and restarts at the code MSB
    p_reload_msb_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (chip == CODE[LEN-1]));
endmodule

// File: rtl/dsss_phase_fsm.sv
module dsss_phase_fsm
    import dsss_spreader_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   step,
    input  logic   last,
    output phase_e phase
);
    phase_e phase_q, phase_d;

    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE:     if (start) phase_d = PH_PREAMBLE;
            PH_PREAMBLE: if (start) phase_d = PH_PREAMBLE;
                         else if (step && last) phase_d = PH_PAYLOAD;
            PH_PAYLOAD:  if (start) phase_d = PH_PREAMBLE;
            default:     phase_d = PH_IDLE;
        endcase
    end

    assign phase = phase_q;

    // R4: payload only follows the final sync chip step
    p_preamble_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_PAYLOAD && $past(phase_q) == PH_PREAMBLE)
            |-> ($past(step) && $past(last)));
    // R2: start always lands in preamble
    p_start_preamble_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (phase_q == PH_PREAMBLE));
endmodule

// File: rtl/dsss_preamble_spreader.sv
module dsss_preamble_spreader
    import dsss_spreader_pkg::*;
#(
    parameter int             CHIPS     = 8,
    parameter logic [CHIPS-1:0] SYNC_WORD = 8'b1110_0100,
    parameter logic [CHIPS-1:0] CODE_WORD = 8'b1011_0001
) (
    input  logic clk,
    input  logic rst_n,
    input  logic data_bit,
    input  logic sync_load,
    input  logic sync_chip_en,
    input  logic code_load,
    input  logic code_chip_en,
    input  logic out_en,
    output logic line_chip
);
    phase_e phase;
    logic   sync_chip, sync_last, code_chip, next_chip;
    logic   sync_adv, code_adv;

    assign sync_adv = sync_chip_en && (phase == PH_PREAMBLE);
    assign code_adv = code_chip_en && (phase == PH_PAYLOAD);

    dsss_sync_shifter #(.LEN(CHIPS), .WORD(SYNC_WORD)) u_sync (
        .clk(clk), .rst_n(rst_n), .load(sync_load), .advance(sync_adv),
        .chip(sync_chip), .last(sync_last)
    );

    dsss_code_rotator #(.LEN(CHIPS), .CODE(CODE_WORD)) u_code (
        .clk(clk), .rst_n(rst_n), .load(code_load), .advance(code_adv),
        .chip(code_chip)
    );

    dsss_phase_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start(sync_load), .step(sync_chip_en),
        .last(sync_last), .phase(phase)
    );

    always_comb begin
        next_chip = 1'b0;
        unique case (phase)
            PH_IDLE:     next_chip = 1'b0;
            PH_PREAMBLE: next_chip = sync_chip;
            PH_PAYLOAD:  next_chip = data_bit ^ code_chip;
            default:     next_chip = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      line_chip <= 1'b0;
        else if (out_en) line_chip <= next_chip;
    end

    // R1: the line stays quiet until a preamble starts
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> (line_chip == 1'b0));
    // R7: enabled output register follows the chip of the previous clock
    p_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_en |=> (line_chip == $past(next_chip)));
    // R7: disabled output register holds
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |=> $stable(line_chip));
    // R5: the code does not move outside payload unless reloaded
    p_code_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_PAYLOAD && !code_load) |=> $stable(code_chip));
endmodule

// File: tb/dsss_preamble_spreader_test.sv
module dsss_preamble_spreader_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic data_bit = 1'b0, sync_load = 1'b0, sync_chip_en = 1'b0;
    logic code_load = 1'b0, code_chip_en = 1'b0, out_en = 1'b1;
    logic line_chip;

    localparam logic [7:0] SW = 8'b1110_0100;
    localparam logic [7:0] CW = 8'b1011_0001;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    // behavioural reference: 0 idle, 1 preamble, 2 payload
    int m_state = 0, m_sidx = 0, m_cpos = 0;
    logic m_out = 1'b0;
    logic m_prev_oe = 1'b1;

    always #2 clk = ~clk;

    dsss_preamble_spreader uut (
        .clk(clk), .rst_n(rst_n), .data_bit(data_bit), .sync_load(sync_load),
        .sync_chip_en(sync_chip_en), .code_load(code_load),
        .code_chip_en(code_chip_en), .out_en(out_en), .line_chip(line_chip)
    );

    always @(posedge clk) begin
        logic chip;
        int   st;
        st = m_state;
        m_prev_oe = out_en;
        if (!rst_n) begin
            m_state = 0; m_sidx = 0; m_cpos = 0; m_out = 1'b0;
        end else begin
            if (st == 0)      chip = 1'b0;
            else if (st == 1) chip = SW[7 - m_sidx];
            else              chip = data_bit ^ CW[7 - m_cpos];
            if (out_en) m_out = chip;
            if (sync_load) begin
                m_state = 1; m_sidx = 0;
            end else if (st == 1 && sync_chip_en) begin
                m_sidx = m_sidx + 1;
                if (m_sidx == 8) begin m_state = 2; m_sidx = 0; end
            end
            if (code_load)                     m_cpos = 0;
            else if (st == 2 && code_chip_en)  m_cpos = (m_cpos + 1) % 8;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            string tag;
            if (!m_prev_oe)        tag = "R7";
            else if (m_state == 0) tag = "R1";
            else if (m_state == 1) tag = "R3 R4";
            else                   tag = "R5";
            checks++;
            if (line_chip !== m_out) begin
                fails++;
                $display("FAIL %s: line_chip=%b expected %b at %0t", tag, line_chip, m_out, $time);
            end
        end
    end

    task automatic cyc(input logic sl, input logic cl, input logic en);
        @(negedge clk);
        sync_load = sl; code_load = cl;
        sync_chip_en = en; code_chip_en = en;
    endtask

    // one chip period of four clocks, enable on the last
    task automatic chip_period();
        cyc(0, 0, 0); cyc(0, 0, 0); cyc(0, 0, 0); cyc(0, 0, 1);
    endtask

    task automatic send_frame(input logic [11:0] frame, input int bits);
        cyc(1, 1, 0);                       // R2: START
        for (int i = 0; i < 8; i++) chip_period();
        for (int b = 11; b > 11 - bits; b--) begin
            data_bit = frame[b];
            for (int c = 0; c < 8; c++) chip_period();
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: run hung, actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        checks++;                                  // R1 reset state
        if (line_chip !== 1'b0) begin
            fails++; $display("FAIL R1: line_chip=%b expected 0 in reset", line_chip);
        end
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 3; i++) chip_period(); // R1: enables ignored in idle
        send_frame(12'hA5C, 12);                   // R3 R4 R5 full frame
        out_en = 1'b0;                             // R7 hold
        for (int i = 0; i < 3; i++) chip_period();
        out_en = 1'b1;
        send_frame(12'h3E1, 3);
        cyc(0, 1, 1);                              // R6 R8 reload beats enable
        for (int i = 0; i < 10; i++) chip_period();
        cyc(1, 0, 1);                              // R2 R8 restart mid-payload
        for (int i = 0; i < 20; i++) chip_period();
        data_bit = 1'b1;
        for (int i = 0; i < 8; i++) chip_period();
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule